// File: doc/BRIEF.md
# Microcode Template Store with Two-Way Fetch Arbiter

This block holds the microcode template words of a display controller and serves instruction fetches from two microcode address generators. Each template word is 42 bits wide. The host bus is 32 bits wide, so the host writes a word in two steps. The first access loads the low 32 bits into a staging register. The second access supplies the top 10 bits, and the full word is committed to the addressed entry in that same cycle.

The two address generators share one read port. When both request a fetch in the same cycle, they take turns in round-robin order. There is one exception: if exactly one of the two requests belongs to a synchronous display flow, that request wins and the turn order is left unchanged. The selected word is read one cycle after the grant. It is returned already split into a stop flag, a 9-bit opcode and a 32-bit operand. Reset does not clear the template contents.

Each fetch requester uses a valid/ready handshake. A requester raises its valid bit and presents its address. Its ready bit is the grant. Once valid is raised, the requester must keep valid high and the address unchanged until it sees ready. The response side has no back-pressure: the consumer must take the response in the cycle in which `rsp_valid` is high. The host write port is a plain strobe and is always accepted.

Top module: `ucode_tmpl_mem`

## Requirements
- R1: After reset, `rsp_valid` is 0, `fetch_ready` is 0 while no request is valid, the staging register is zero and requester 0 holds the round-robin turn.
- R2: A host access with `host_wr_en`=1 and `host_wr_hi`=0 loads `host_wr_data[31:0]` into the staging register and changes no template entry.
- R3: A host access with `host_wr_en`=1 and `host_wr_hi`=1 writes `{host_wr_data[9:0], staging}` to entry `host_wr_addr`. `host_wr_data[31:10]` is ignored. The staging register keeps its value, so a later high access reuses it.
- R4: In each cycle, at most one bit of `fetch_ready` is high, and only for a requester whose valid bit is high. Any cycle with at least one valid request grants one of them. A requester that is valid and not granted keeps valid high and its address unchanged in the next cycle.
- R5: When both requesters are valid and exactly one of them has its `fetch_sync` bit set, that requester is granted. This grant does not change the round-robin turn.
- R6: Every grant made without the R5 override passes the turn to the other requester. This includes a grant to a lone requester. When both requesters are valid with equal sync bits, the turn holder is granted.
- R7: In the cycle after a grant, `rsp_valid` is 1 and `rsp_src` holds the granted requester index. In the cycle after a cycle with no grant, `rsp_valid` is 0.
- R8: The response fields are word bit 41 on `rsp_stop`, bits 40:32 on `rsp_opcode` and bits 31:0 on `rsp_operand`.
- R9: If a host commit and a fetch of the same entry happen in the same cycle, the fetch returns the entry's previous contents. The next fetch returns the new word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_wr_en | input | 1 | Host write strobe |
| host_wr_hi | input | 1 | 0: low half into staging; 1: top bits and commit |
| host_wr_addr | input | 8 | Template entry written on commit |
| host_wr_data | input | 32 | Host write data |
| fetch_valid | input | 2 | Per-requester fetch valid |
| fetch_sync | input | 2 | Per-requester flag: request belongs to a synchronous flow |
| fetch_addr | input | 16 | Requester 0 address in [7:0], requester 1 in [15:8] |
| fetch_ready | output | 2 | Per-requester grant (ready) |
| rsp_valid | output | 1 | Fetched word is valid this cycle |
| rsp_src | output | 1 | Index of the requester the response belongs to |
| rsp_stop | output | 1 | Stop flag of the fetched word |
| rsp_opcode | output | 9 | Opcode field of the fetched word |
| rsp_operand | output | 32 | Operand field of the fetched word |

## Verification
The checker assumes that each requester follows the hold rule: a pending request keeps its valid bit and its address until it is granted. It also assumes that no request is raised while reset is asserted. The bench keeps to both rules. Each arbitration sequence ends with a cycle in which only the requester left waiting is valid, so no pending request is ever withdrawn. All inputs are held idle during reset. The round-robin alternation check is enabled only one cycle after reset is released, so it never compares against a cycle spent in reset.

// File: rtl/ucode_tmpl_pkg.sv
package ucode_tmpl_pkg;
  localparam int TMPL_W   = 42;
  localparam int HOST_W   = 32;
  localparam int HI_W     = TMPL_W - HOST_W;
  localparam int OPC_W    = 9;
  localparam int OPD_W    = TMPL_W - OPC_W - 1;
  localparam int N_FETCH  = 2;

  typedef struct packed {
    logic             stop;
    logic [OPC_W-1:0] opcode;
    logic [OPD_W-1:0] operand;
  } tmpl_word_t;
endpackage

// File: rtl/ucode_tmpl_stage.sv
module ucode_tmpl_stage
  import ucode_tmpl_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              wr_hi,
  input  logic [HOST_W-1:0] wr_data,
  output logic              commit_en,
  output tmpl_word_t        commit_word
);
  logic [HOST_W-1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      stage_q <= '0;
    else if (wr_en && !wr_hi)
      stage_q <= wr_data;
  end

  always_comb begin
    commit_en   = wr_en && wr_hi;
    commit_word = tmpl_word_t'({wr_data[HI_W-1:0], stage_q});
  end
endmodule

// File: rtl/ucode_tmpl_arb.sv
module ucode_tmpl_arb
  import ucode_tmpl_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic [N_FETCH-1:0] req_valid,
  input  logic [N_FETCH-1:0] req_sync,
  output logic [N_FETCH-1:0] grant,
  output logic               grant_idx,
  output logic               grant_any
);
  logic turn_q;
  logic both;
  logic override;

  always_comb begin
    both     = &req_valid;
    override = both && (req_sync[0] ^ req_sync[1]);
    if (override)
      grant = req_sync;
    else if (both)
      grant = turn_q ? 2'b10 : 2'b01;
    else
      grant = req_valid;
    grant_any = |grant;
    grant_idx = grant[1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      turn_q <= 1'b0;
    else if (grant_any && !override)
      turn_q <= ~grant_idx;
  end
endmodule

// File: rtl/ucode_tmpl_store.sv
module ucode_tmpl_store
  import ucode_tmpl_pkg::*;
#(
  parameter  int DEPTH  = 256,
  localparam int ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  tmpl_word_t        wr_word,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output tmpl_word_t        rd_word
);
  tmpl_word_t mem [DEPTH];

  // Read-before-write: a same-edge read sees the old entry.
  always_ff @(posedge clk) begin
    if (wr_en)
      mem[wr_addr] <= wr_word;
    if (rd_en)
      rd_word <= mem[rd_addr];
  end
endmodule

// File: rtl/ucode_tmpl_decode.sv
module ucode_tmpl_decode
  import ucode_tmpl_pkg::*;
(
  input  tmpl_word_t       word,
  output logic             stop,
  output logic [OPC_W-1:0] opcode,
  output logic [OPD_W-1:0] operand
);
  always_comb begin
    stop    = word.stop;
    opcode  = word.opcode;
    operand = word.operand;
  end
endmodule

// File: rtl/ucode_tmpl_mem.sv
module ucode_tmpl_mem
  import ucode_tmpl_pkg::*;
#(
  parameter  int DEPTH  = 256,
  localparam int ADDR_W = $clog2(DEPTH)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      host_wr_en,
  input  logic                      host_wr_hi,
  input  logic [ADDR_W-1:0]         host_wr_addr,
  input  logic [HOST_W-1:0]         host_wr_data,
  input  logic [N_FETCH-1:0]        fetch_valid,
  input  logic [N_FETCH-1:0]        fetch_sync,
  input  logic [N_FETCH*ADDR_W-1:0] fetch_addr,
  output logic [N_FETCH-1:0]        fetch_ready,
  output logic                      rsp_valid,
  output logic                      rsp_src,
  output logic                      rsp_stop,
  output logic [OPC_W-1:0]          rsp_opcode,
  output logic [OPD_W-1:0]          rsp_operand
);
  logic              commit_en;
  tmpl_word_t        commit_word;
  logic              grant_idx;
  logic              grant_any;
  logic [ADDR_W-1:0] sel_addr;
  tmpl_word_t        rd_word;

  ucode_tmpl_stage u_stage (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_en       (host_wr_en),
    .wr_hi       (host_wr_hi),
    .wr_data     (host_wr_data),
    .commit_en   (commit_en),
    .commit_word (commit_word)
  );

  ucode_tmpl_arb u_arb (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (fetch_valid),
    .req_sync  (fetch_sync),
    .grant     (fetch_ready),
    .grant_idx (grant_idx),
    .grant_any (grant_any)
  );

  always_comb begin
    sel_addr = grant_idx ? fetch_addr[2*ADDR_W-1:ADDR_W] : fetch_addr[ADDR_W-1:0];
  end

  ucode_tmpl_store #(.DEPTH(DEPTH)) u_store (
    .clk     (clk),
    .wr_en   (commit_en),
    .wr_addr (host_wr_addr),
    .wr_word (commit_word),
    .rd_en   (grant_any),
    .rd_addr (sel_addr),
    .rd_word (rd_word)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_src   <= 1'b0;
    end else begin
      rsp_valid <= grant_any;
      if (grant_any)
        rsp_src <= grant_idx;
    end
  end

  ucode_tmpl_decode u_decode (
    .word    (rd_word),
    .stop    (rsp_stop),
    .opcode  (rsp_opcode),
    .operand (rsp_operand)
  );
endmodule

// File: rtl/ucode_tmpl_mem_chk.sv
module ucode_tmpl_mem_chk #(
  parameter int ADDR_W = 8
) (
  input logic                clk,
  input logic                rst_n,
  input logic [1:0]          fetch_valid,
  input logic [1:0]          fetch_sync,
  input logic [2*ADDR_W-1:0] fetch_addr,
  input logic [1:0]          fetch_ready,
  input logic                rsp_valid,
  input logic                rsp_src
);
  logic armed;
  logic tie;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed <= 1'b0;
    else        armed <= 1'b1;
  end

  assign tie = (&fetch_valid) && (fetch_sync[0] == fetch_sync[1]);

  a_r4_onehot_grant: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(fetch_ready));

  a_r4_grant_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_ready & ~fetch_valid) == 2'b00);

  a_r4_work_conserving: assert property (@(posedge clk) disable iff (!rst_n)
    (|fetch_valid) |-> (|fetch_ready));

  a_r4_hold_req0: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_valid[0] && !fetch_ready[0]) |=>
      (fetch_valid[0] && fetch_addr[ADDR_W-1:0] == $past(fetch_addr[ADDR_W-1:0])));

  a_r4_hold_req1: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_valid[1] && !fetch_ready[1]) |=>
      (fetch_valid[1] && fetch_addr[2*ADDR_W-1:ADDR_W] == $past(fetch_addr[2*ADDR_W-1:ADDR_W])));

  a_r5_sync_preferred: assert property (@(posedge clk) disable iff (!rst_n)
    ((&fetch_valid) && (fetch_sync[0] != fetch_sync[1])) |-> (fetch_ready == fetch_sync));

  a_r6_alternate: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && tie && $past(tie)) |-> (fetch_ready != $past(fetch_ready)));

  a_r7_rsp_after_grant: assert property (@(posedge clk) disable iff (!rst_n)
    (|fetch_ready) |=> (rsp_valid && rsp_src == $past(fetch_ready[1])));

  a_r7_no_rsp_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !(|fetch_ready) |=> !rsp_valid);
endmodule

bind ucode_tmpl_mem ucode_tmpl_mem_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .fetch_valid (fetch_valid),
  .fetch_sync  (fetch_sync),
  .fetch_addr  (fetch_addr),
  .fetch_ready (fetch_ready),
  .rsp_valid   (rsp_valid),
  .rsp_src     (rsp_src)
);

// File: tb/ucode_tmpl_mem_tb.sv
module ucode_tmpl_mem_tb;
  localparam logic [7:0] A0 = 8'h10;
  localparam logic [7:0] A1 = 8'h20;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        host_wr_en, host_wr_hi;
  logic [7:0]  host_wr_addr;
  logic [31:0] host_wr_data;
  logic [1:0]  fetch_valid, fetch_sync, fetch_ready;
  logic [15:0] fetch_addr;
  logic        rsp_valid, rsp_src, rsp_stop;
  logic [8:0]  rsp_opcode;
  logic [31:0] rsp_operand;

  int checks = 0;
  int failures = 0;
  logic [41:0] exp_mem [256];
  logic [31:0] exp_stage;

  always #10 clk = ~clk;

  ucode_tmpl_mem u_dut (
    .clk(clk), .rst_n(rst_n),
    .host_wr_en(host_wr_en), .host_wr_hi(host_wr_hi),
    .host_wr_addr(host_wr_addr), .host_wr_data(host_wr_data),
    .fetch_valid(fetch_valid), .fetch_sync(fetch_sync), .fetch_addr(fetch_addr),
    .fetch_ready(fetch_ready), .rsp_valid(rsp_valid), .rsp_src(rsp_src),
    .rsp_stop(rsp_stop), .rsp_opcode(rsp_opcode), .rsp_operand(rsp_operand)
  );

  task automatic check_eq(input string req, input string what,
                          input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic drive_idle();
    host_wr_en = 0; host_wr_hi = 0; host_wr_addr = 0; host_wr_data = 0;
    fetch_valid = 0; fetch_sync = 0; fetch_addr = 0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0;
    drive_idle();
    repeat (3) @(negedge clk);
    rst_n = 1;
    exp_stage = '0;
  endtask

  task automatic host_access(input logic [7:0] a, input logic hi, input logic [31:0] d);
    @(negedge clk);
    host_wr_en = 1; host_wr_hi = hi; host_wr_addr = a; host_wr_data = d;
    @(negedge clk);
    host_wr_en = 0; host_wr_hi = 0;
    if (!hi) exp_stage = d;
    else     exp_mem[a] = {d[9:0], exp_stage};
  endtask

  task automatic write_word(input logic [7:0] a, input logic [41:0] w);
    host_access(a, 1'b0, w[31:0]);
    host_access(a, 1'b1, {22'h2AAAAA, w[41:32]});
  endtask

  task automatic check_rsp(input string req, input logic id, input logic [41:0] w);
    check_eq(req, "rsp_valid", rsp_valid, 1);
    check_eq(req, "rsp_src", rsp_src, id);
    check_eq("R8", "rsp_stop", rsp_stop, w[41]);
    check_eq("R8", "rsp_opcode", rsp_opcode, w[40:32]);
    check_eq("R8", "rsp_operand", rsp_operand, w[31:0]);
  endtask

  task automatic fetch_one(input logic id, input logic [7:0] a, input logic s, input string req);
    @(negedge clk);
    fetch_valid = id ? 2'b10 : 2'b01;
    fetch_sync  = s ? fetch_valid : 2'b00;
    fetch_addr  = id ? {a, 8'h00} : {8'h00, a};
    #1 check_eq("R4", "fetch_ready lone", fetch_ready, fetch_valid);
    @(negedge clk);
    check_rsp(req, id, exp_mem[a]);
    fetch_valid = 0; fetch_sync = 0;
  endtask

  // Called at a negedge; returns at the next negedge.
  task automatic arb_step(input logic [1:0] v, input logic [1:0] s,
                          input logic [1:0] exp_g, input string req);
    fetch_valid = v; fetch_sync = s; fetch_addr = {A1, A0};
    #1 check_eq(req, "grant", fetch_ready, exp_g);
    @(negedge clk);
    check_rsp(req, exp_g[1], exp_mem[exp_g[1] ? A1 : A0]);
  endtask

  task automatic test_reset();
    do_reset();
    #1;
    check_eq("R1", "rsp_valid after reset", rsp_valid, 0);
    check_eq("R1", "fetch_ready idle", fetch_ready, 0);
  endtask

  task automatic test_basic();
    write_word(A0, {1'b1, 9'h1A5, 32'hDEADBEEF});
    write_word(A1, {1'b0, 9'h05A, 32'h0BADF00D});
    write_word(8'hFF, {1'b1, 9'h1FF, 32'hFFFFFFFF});
    write_word(8'h00, {1'b0, 9'h000, 32'h00000001});
    fetch_one(1'b0, A0, 1'b0, "R3");
    fetch_one(1'b1, A1, 1'b1, "R3");
    fetch_one(1'b0, 8'hFF, 1'b0, "R3");
    fetch_one(1'b1, 8'h00, 1'b0, "R3");
  endtask

  task automatic test_staging();
    host_access(A0, 1'b0, 32'h12345678);
    fetch_one(1'b0, A0, 1'b0, "R2");
    host_access(8'h40, 1'b1, {22'h3FFFFF, 10'h155});
    fetch_one(1'b0, 8'h40, 1'b0, "R3");
    host_access(8'h41, 1'b1, {22'h000001, 10'h2AA});
    fetch_one(1'b1, 8'h41, 1'b0, "R3");
    write_word(A0, {1'b1, 9'h1A5, 32'hDEADBEEF});
  endtask

  task automatic test_round_robin();
    do_reset();
    @(negedge clk);
    arb_step(2'b11, 2'b00, 2'b01, "R1");
    arb_step(2'b11, 2'b00, 2'b10, "R6");
    arb_step(2'b11, 2'b00, 2'b01, "R6");
    arb_step(2'b11, 2'b11, 2'b10, "R6");
    arb_step(2'b01, 2'b00, 2'b01, "R6");
    drive_idle();
  endtask

  task automatic test_sync_override();
    do_reset();
    @(negedge clk);
    arb_step(2'b11, 2'b10, 2'b10, "R5");
    arb_step(2'b11, 2'b10, 2'b10, "R5");
    arb_step(2'b11, 2'b00, 2'b01, "R5");
    arb_step(2'b10, 2'b00, 2'b10, "R6");
    arb_step(2'b11, 2'b01, 2'b01, "R5");
    arb_step(2'b10, 2'b00, 2'b10, "R5");
    drive_idle();
  endtask

  task automatic test_lone_toggle();
    do_reset();
    @(negedge clk);
    arb_step(2'b10, 2'b00, 2'b10, "R6");
    arb_step(2'b11, 2'b11, 2'b01, "R6");
    arb_step(2'b10, 2'b00, 2'b10, "R6");
    drive_idle();
  endtask

  task automatic test_same_cycle();
    logic [41:0] old_w;
    write_word(8'h30, {1'b0, 9'h123, 32'h11112222});
    host_access(8'h30, 1'b0, 32'hCAFEF00D);
    old_w = exp_mem[8'h30];
    @(negedge clk);
    host_wr_en = 1; host_wr_hi = 1; host_wr_addr = 8'h30; host_wr_data = {22'h0, 10'h2C3};
    fetch_valid = 2'b01; fetch_sync = 0; fetch_addr = {8'h00, 8'h30};
    @(negedge clk);
    check_rsp("R9", 1'b0, old_w);
    host_wr_en = 0; host_wr_hi = 0; fetch_valid = 0;
    exp_mem[8'h30] = {10'h2C3, 32'hCAFEF00D};
    fetch_one(1'b0, 8'h30, 1'b0, "R9");
  endtask

  task automatic test_idle();
    @(negedge clk);
    drive_idle();
    @(negedge clk);
    check_eq("R7", "rsp_valid idle", rsp_valid, 0);
  endtask

  initial begin
    drive_idle();
    test_reset();
    test_basic();
    test_staging();
    test_round_robin();
    test_sync_override();
    test_lone_toggle();
    test_same_cycle();
    test_idle();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule